// File: doc/BRIEF.md
# Watchdog Timer with Clock-Settling Mode

This block is an 8-bit up-counter driven by a selectable prescaler, and it serves three purposes. In watchdog mode an overflow sets a sticky flag and raises a reset request of a selectable kind. The request stays high for a fixed number of input-clock cycles. Software prevents this by rewriting the counter before it wraps. In interval mode an overflow sets the same flag and gives a one-cycle interrupt pulse, and the counter keeps running.

The third purpose supports a frequency change. Software first clears the enable bit and loads a start value. A one-cycle frequency-change strobe then gates the processor clock off. The counter runs from the loaded value whether or not it is enabled. When it wraps, the clock is released and the flag stays untouched. The counter then parks at zero until software writes it again.

Software reaches the block over a small register bus. There are two registers, and a key byte in the upper half of each write guards them against stray stores.

Top module: `wdt_settle_top`

## Requirements
- R1: After reset the counter reads 0x00, the control register reads 0x00, the clock-run output is 1, and the reset-request and interrupt outputs are 0.
- R2: A write to the counter (select 0) takes effect only when write data bits 15:8 equal 0x5A. A write to the control register (select 1) takes effect only when those bits equal 0xA5. Any other write changes nothing.
- R3: Outside settling and parking, the counter advances by one on each prescaled tick, and only while the enable bit (control bit 5) is 1. The select field (control bits 2:0) picks the ratio 1, 4, 16, 32, 64, 256, 1024 or 4096 for codes 0 to 7. The prescaler restarts from zero whenever counting is stopped.
- R4: In watchdog mode (control bit 6 = 1), a tick at 0xFF wraps the counter to 0x00 and sets the flag. It also drives the reset request high for exactly RST_HOLD cycles, starting the cycle after the wrap, while the counter continues counting.
- R5: In interval mode (control bit 6 = 0), a wrap sets the flag and pulses the interrupt for one cycle, with no reset request.
- R6: The reset-kind output always follows control bit 4.
- R7: The flag (control bit 7) is cleared by a keyed control write with bit 7 = 0. Writing 1 to it leaves it unchanged. An overflow in the same cycle as a clearing write leaves the flag set.
- R8: The cycle after a frequency-change strobe, the clock-run output is 0. The counter then counts from its current value at the selected ratio, regardless of the enable bit.
- R9: A wrap while settling sets clock-run back to 1 and parks the counter at 0x00. It does not set the flag and raises neither a reset request nor an interrupt. A parked counter holds 0x00 even when enabled, until a keyed counter write.
- R10: A keyed counter write in the same cycle as a would-be overflow takes priority: the written value is loaded and no overflow occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWr | input | 1 | Register write strobe |
| busSel | input | 1 | Register select: 0 counter, 1 control |
| busWdata | input | 16 | Write data: key in 15:8, value in 7:0 |
| busRdata | output | 8 | Read data of the selected register |
| freqChg | input | 1 | Frequency-change strobe |
| clkRun | output | 1 | Processor clock enable |
| rstReq | output | 1 | Reset request |
| rstKind | output | 1 | Kind of reset requested |
| irq | output | 1 | Interval interrupt pulse |

## Verification
The collision of interest is a software kick landing on the very tick that would wrap the counter. The bench watches the count at the falling edge. When it reads 0xFF with the divide-by-one clock, the bench issues a keyed counter write for the next rising edge. The expected result is the written value with the flag still clear and no reset request. A reference model updated every rising edge also covers a control write that clears the flag in a cycle where an overflow sets it; in that case the set must win.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef struct packed {
    logic       cntLoad;
    logic       cntClear;
    logic       prescRun;
    logic [3:0] prescShift;
  } cnt_strobe_t;

  function automatic logic [3:0] sel_to_shift(input logic [2:0] sel);
    case (sel)
      3'd0: sel_to_shift = 4'd0;
      3'd1: sel_to_shift = 4'd2;
      3'd2: sel_to_shift = 4'd4;
      3'd3: sel_to_shift = 4'd5;
      3'd4: sel_to_shift = 4'd6;
      3'd5: sel_to_shift = 4'd8;
      3'd6: sel_to_shift = 4'd10;
      default: sel_to_shift = 4'd12;
    endcase
  endfunction
endpackage

// File: rtl/wdt_datapath.sv
module wdt_datapath
  import wdt_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int PRESC_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_strobe_t      strb,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cnt,
  output logic             tick,
  output logic             atMax
);
  logic [PRESC_W-1:0] presc;
  logic [PRESC_W-1:0] prescMask;

  assign prescMask = ~({PRESC_W{1'b1}} << strb.prescShift);
  assign tick      = strb.prescRun && ((presc & prescMask) == prescMask);
  assign atMax     = (cnt == {CNT_W{1'b1}});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc <= '0;
    end else if (strb.prescRun) begin
      presc <= presc + 1'b1;
    end else begin
      presc <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.cntLoad) begin
      cnt <= loadVal;
    end else if (strb.cntClear) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= cnt + 1'b1;
    end
  end

  // R3: with no load, clear or tick, the count must hold
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.cntLoad && !strb.cntClear && !tick) |=> (cnt == $past(cnt)));

  // R4: a plain tick at the top value wraps to zero
  assert_wrap_R4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && atMax && !strb.cntLoad && !strb.cntClear) |=> (cnt == '0));
endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl
  import wdt_pkg::*;
#(
  parameter int          RST_HOLD = 128,
  parameter logic [7:0]  CNT_KEY  = 8'h5A,
  parameter logic [7:0]  CTL_KEY  = 8'hA5,
  localparam int         HOLD_W   = $clog2(RST_HOLD + 1)
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busSel,
  input  logic [15:0] busWdata,
  input  logic        freqChg,
  input  logic        tick,
  input  logic        atMax,
  output cnt_strobe_t strb,
  output logic [7:0]  ctlView,
  output logic        clkRun,
  output logic        rstReq,
  output logic        rstKind,
  output logic        irq
);
  logic             enable, modeWd, rstType, ovfFlag;
  logic [2:0]       clkSel;
  logic             settling, parked;
  logic [HOLD_W-1:0] holdCnt;
  logic             cntWr, ctlWr, ovfEvt, settleOvf, normOvf;

  assign cntWr     = busWr && !busSel && (busWdata[15:8] == CNT_KEY);
  assign ctlWr     = busWr &&  busSel && (busWdata[15:8] == CTL_KEY);
  assign ovfEvt    = tick && atMax && !cntWr;
  assign settleOvf = settling && ovfEvt && !freqChg;
  assign normOvf   = !settling && ovfEvt;

  assign strb.cntLoad    = cntWr;
  assign strb.cntClear   = settleOvf;
  assign strb.prescRun   = settling || (enable && !parked);
  assign strb.prescShift = sel_to_shift(clkSel);

  assign ctlView = {ovfFlag, modeWd, enable, rstType, 1'b0, clkSel};
  assign clkRun  = !settling;
  assign rstReq  = (holdCnt != '0);
  assign rstKind = rstType;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= 1'b0;
      modeWd   <= 1'b0;
      rstType  <= 1'b0;
      clkSel   <= '0;
      ovfFlag  <= 1'b0;
      settling <= 1'b0;
      parked   <= 1'b0;
      holdCnt  <= '0;
      irq      <= 1'b0;
    end else begin
      if (ctlWr) begin
        ovfFlag <= ovfFlag & busWdata[7];
        modeWd  <= busWdata[6];
        enable  <= busWdata[5];
        rstType <= busWdata[4];
        clkSel  <= busWdata[2:0];
      end
      if (normOvf) ovfFlag <= 1'b1;

      if (freqChg)        settling <= 1'b1;
      else if (settleOvf) settling <= 1'b0;

      if (cntWr)          parked <= 1'b0;
      else if (settleOvf) parked <= 1'b1;

      if (normOvf && modeWd)   holdCnt <= HOLD_W'(RST_HOLD);
      else if (holdCnt != '0)  holdCnt <= holdCnt - 1'b1;

      irq <= normOvf && !modeWd;
    end
  end

  // R8: the strobe gates the clock off on the next cycle
  assert_clk_gate_R8: assert property (@(posedge clk) disable iff (!rstN)
    freqChg |=> !clkRun);

  // R9: a settling wrap frees the clock and leaves the flag alone
  assert_settle_flag_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!clkRun && tick && atMax && !cntWr && !ctlWr && !freqChg)
      |=> (clkRun && ovfFlag == $past(ovfFlag) && !irq));

  // R5: the interrupt is a single-cycle pulse from interval mode
  assert_irq_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    irq |=> !irq);
  assert_irq_mode_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (!rstReq || $past(rstReq)));
endmodule

// File: rtl/wdt_settle_top.sv
module wdt_settle_top #(
  parameter int RST_HOLD = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWr,
  input  logic        busSel,
  input  logic [15:0] busWdata,
  output logic [7:0]  busRdata,
  input  logic        freqChg,
  output logic        clkRun,
  output logic        rstReq,
  output logic        rstKind,
  output logic        irq
);
  wdt_pkg::cnt_strobe_t strb;
  logic [7:0] cnt, ctlView;
  logic       tick, atMax;

  wdt_ctrl #(.RST_HOLD(RST_HOLD)) uCtrl (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel),
    .busWdata(busWdata), .freqChg(freqChg), .tick(tick), .atMax(atMax),
    .strb(strb), .ctlView(ctlView), .clkRun(clkRun), .rstReq(rstReq),
    .rstKind(rstKind), .irq(irq)
  );

  wdt_datapath #(.CNT_W(8), .PRESC_W(12)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .loadVal(busWdata[7:0]),
    .cnt(cnt), .tick(tick), .atMax(atMax)
  );

  assign busRdata = busSel ? ctlView : cnt;
endmodule

// File: tb/tb_wdt_settle_top.sv
module tb_wdt_settle_top;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 20;

  logic clk = 1'b0, rstN = 1'b0;
  logic busWr = 1'b0, busSel = 1'b0, freqChg = 1'b0;
  logic [15:0] busWdata = '0;
  logic [7:0] busRdata;
  logic clkRun, rstReq, rstKind, irq;

  int checks = 0, errors = 0;
  bit done = 0;

  wdt_settle_top #(.RST_HOLD(HOLD)) dut (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busSel(busSel),
    .busWdata(busWdata), .busRdata(busRdata), .freqChg(freqChg),
    .clkRun(clkRun), .rstReq(rstReq), .rstKind(rstKind), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Reference model state
  int mCnt, mPresc, mSel, mHold;
  bit mEn, mMode, mType, mFlag, mSettle, mPark, mIrq;

  function automatic int ratioOf(int sel);
    int r[8] = '{1, 4, 16, 32, 64, 256, 1024, 4096};
    return r[sel];
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mPresc = 0; mSel = 0; mHold = 0;
      mEn = 0; mMode = 0; mType = 0; mFlag = 0; mSettle = 0; mPark = 0; mIrq = 0;
    end else begin
      bit wrC, wrK, run, tk, ovf, sOvf, nOvf;
      wrC  = busWr && !busSel && busWdata[15:8] == 8'h5A;
      wrK  = busWr && busSel && busWdata[15:8] == 8'hA5;
      run  = mSettle || (mEn && !mPark);
      tk   = run && ((mPresc % ratioOf(mSel)) == ratioOf(mSel) - 1);
      ovf  = tk && mCnt == 255 && !wrC;
      sOvf = mSettle && ovf && !freqChg;
      nOvf = !mSettle && ovf;
      mIrq = nOvf && !mMode;
      if (nOvf && mMode) mHold = HOLD; else if (mHold > 0) mHold--;
      if (wrC) mCnt = busWdata[7:0];
      else if (sOvf) mCnt = 0;
      else if (tk) mCnt = (mCnt + 1) % 256;
      mPresc = run ? (mPresc + 1) % 4096 : 0;
      if (wrK) begin
        if (!busWdata[7]) mFlag = 0;
        mMode = busWdata[6]; mEn = busWdata[5]; mType = busWdata[4];
        mSel = busWdata[2:0];
      end
      if (nOvf) mFlag = 1;
      if (freqChg) mSettle = 1; else if (sOvf) mSettle = 0;
      if (wrC) mPark = 0; else if (sOvf) mPark = 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison of ports against the model
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk("R8 clkRun", clkRun, !mSettle);
      chk("R4 rstReq", rstReq, mHold != 0);
      chk("R5 irq", irq, mIrq);
      chk("R6 rstKind", rstKind, mType);
      if (!busWr) begin
        if (busSel) chk("R7 ctrl", busRdata, {mFlag, mMode, mEn, mType, 1'b0, mSel[2:0]});
        else        chk("R3 cnt", busRdata, mCnt);
      end
    end
  end

  task automatic wr(bit sel, logic [7:0] key, logic [7:0] val);
    busWr = 1; busSel = sel; busWdata = {key, val};
    @(negedge clk);
    busWr = 0; busWdata = '0;
  endtask

  task automatic rd(bit sel, output logic [7:0] v);
    busSel = sel; #1; v = busRdata;
  endtask

  task automatic waitc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    int highCycles;
    repeat (3) @(negedge clk);
    #1 rstN = 1;
    @(negedge clk);
    // R1 reset state
    rd(0, v); chk("R1 cnt", v, 0);
    rd(1, v); chk("R1 ctrl", v, 0);
    chk("R1 clkRun", clkRun, 1); chk("R1 rstReq", rstReq, 0); chk("R1 irq", irq, 0);

    // R2 key guard
    wr(0, 8'h00, 8'h33); rd(0, v); chk("R2 bad key cnt", v, 0);
    wr(1, 8'h5A, 8'h21); rd(1, v); chk("R2 bad key ctrl", v, 0);
    wr(0, 8'h5A, 8'h33); rd(0, v); chk("R2 good key cnt", v, 8'h33);

    // R3 counting at ratio 4, then frozen when disabled
    wr(1, 8'hA5, 8'h21); waitc(40);
    rd(0, v); chk("R3 advanced", v, 8'h33 + 10);
    wr(1, 8'hA5, 8'h01); rd(0, v);
    waitc(20); begin logic [7:0] w; rd(0, w); chk("R3 frozen", w, v); end

    // R5 interval overflow at ratio 1
    wr(0, 8'h5A, 8'hF0); wr(1, 8'hA5, 8'h20); waitc(30);
    rd(1, v); chk("R5 flag set", v[7], 1); chk("R5 no reset", rstReq, 0);

    // R7 flag write semantics
    wr(1, 8'hA5, 8'hA0); rd(1, v); chk("R7 write one keeps", v[7], 1);
    wr(1, 8'hA5, 8'h00); rd(1, v); chk("R7 write zero clears", v[7], 0);

    // R4 / R6 watchdog overflow with reset kind 1
    wr(0, 8'h5A, 8'hF8); wr(1, 8'hA5, 8'h70);
    chk("R6 kind", rstKind, 1);
    highCycles = 0;
    repeat (60) begin @(negedge clk); if (rstReq) highCycles++; end
    chk("R4 hold length", highCycles, HOLD);
    rd(1, v); chk("R4 flag", v[7], 1);

    // R10 kick collides with overflow
    wr(1, 8'hA5, 8'h60); wr(0, 8'h5A, 8'hF0);
    begin
      int guard = 0;
      rd(0, v);
      while (v != 8'hFF && guard < 50) begin @(negedge clk); rd(0, v); guard++; end
    end
    wr(0, 8'h5A, 8'h10);
    rd(0, v); chk("R10 loaded", v, 8'h10);
    rd(1, v); chk("R10 no flag", v[7], 0); chk("R10 no reset", rstReq, 0);

    // R8 / R9 settling at ratio 4 with enable cleared
    wr(1, 8'hA5, 8'h01); wr(0, 8'h5A, 8'hF0);
    freqChg = 1; @(negedge clk); freqChg = 0;
    chk("R8 clock off", clkRun, 0);
    waitc(20); rd(0, v); chk("R8 counting", v > 8'hF0, 1);
    waitc(60);
    chk("R9 clock back", clkRun, 1);
    rd(0, v); chk("R9 parked zero", v, 0);
    rd(1, v); chk("R9 flag clear", v[7], 0);
    wr(1, 8'hA5, 8'h20); waitc(20);
    rd(0, v); chk("R9 parked while enabled", v, 0);
    wr(0, 8'h5A, 8'h10); waitc(5);
    rd(0, v); chk("R9 unparked", v, 8'h15);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule